// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block keeps a small bank of transmit mailboxes and chooses which loaded frame goes next to a CAN transmit engine. Software fills each mailbox through a single write port: a mode word (operating mode and a 4-bit priority), an identifier word, two data words and a control word. A control write with the go bit set arms the mailbox. Every armed mailbox in transmit mode competes for the engine. Priority value 0 is the most urgent. When two mailboxes share a priority, the lower mailbox number wins.

The chosen frame is offered on a valid/ready handshake. Until the engine accepts it, the choice is revised every cycle. Once the engine accepts a frame, the choice is frozen and the in-flight mailbox is locked against host writes. The lock lasts until the engine reports that the frame is done or aborted. That report disarms the mailbox, sets its ready flag, records whether it was aborted and raises the mailbox's bit in an interrupt vector. The next control write to that mailbox clears the interrupt bit.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After reset, `tx_valid` is 0, `tx_mb` is 0, every `mb_ready` bit is 1, and every `mb_abort` and `mb_irq` bit is 0.
- R2: A mailbox takes part in arbitration only while it is armed and its mode field (mode word bits 26:24) equals 3. The priority is held in mode word bits 19:16. An armed mailbox in any other mode is never offered.
- R3: Among competing mailboxes, the one with the numerically smallest priority is offered. Priority 0 is the most urgent and 15 the least.
- R4: When several competing mailboxes share the smallest priority, the one with the lowest index is offered.
- R5: A control write (host_sel 4) with bit 23 set arms the mailbox. It latches the DLC from bits 19:16 and the RTR request from bit 20, clears the mailbox's abort flag and drives its `mb_ready` bit low.
- R6: The offered frame shows the identifier from ID word bits 28:0 and the extended flag from bit 29. The data word written with host_sel 2 appears on `tx_data[31:0]` (bytes 0 to 3). The word written with host_sel 3 appears on `tx_data[63:32]` (bytes 4 to 7). host_sel 0 selects the mode word and host_sel 1 the ID word.
- R7: An ID write takes effect only while the mailbox's mode field is 0 (disabled). Otherwise it is ignored.
- R8: While the frame is offered and not yet accepted, the choice is revised every cycle. After acceptance (`tx_valid` and `tx_ready` both high at a clock edge), `tx_valid` stays low and `tx_mb` and the frame stay fixed until a result arrives. Host writes to the in-flight mailbox are ignored during that time.
- R9: `res_done` for the in-flight frame sets that mailbox's `mb_ready` bit, clears its `mb_abort` bit and sets its `mb_irq` bit.
- R10: `res_abort` for the in-flight frame sets that mailbox's `mb_ready`, `mb_abort` and `mb_irq` bits.
- R11: Any control write to a mailbox clears its `mb_irq` bit, whatever the value written.
- R12: When no mailbox competes and no frame is in flight, `tx_valid` is 0 and `tx_mb` keeps its last value.
- R13: `res_done` and `res_abort` have no effect while no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_mb | input | IDX_W | Mailbox addressed by the write |
| host_sel | input | 3 | Word select: 0 mode, 1 ID, 2 data low, 3 data high, 4 control |
| host_wdata | input | 32 | Write data |
| tx_valid | output | 1 | A frame is offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered frame |
| tx_mb | output | IDX_W | Index of the offered or in-flight mailbox |
| tx_id | output | 29 | Frame identifier |
| tx_ext | output | 1 | Extended identifier flag |
| tx_rtr | output | 1 | Remote request flag |
| tx_dlc | output | 4 | Data length code |
| tx_data | output | 64 | Frame payload, byte 0 in bits 7:0 |
| res_done | input | 1 | In-flight frame completed |
| res_abort | input | 1 | In-flight frame aborted |
| mb_ready | output | NUM_MB | Per-mailbox ready flag (low while armed) |
| mb_abort | output | NUM_MB | Per-mailbox abort flag |
| mb_irq | output | NUM_MB | Per-mailbox completion interrupt |

## Verification
The hardest situation to reach is a better mailbox being armed while another frame is already in flight. The bench must show that the grant does not move and that writes to the locked mailbox are dropped. To reach it, the bench first lets a low-priority frame be accepted and withholds the result. It then arms a priority-0 mailbox and rewrites the in-flight one, and checks the frozen outputs before releasing the result. Ordering is swept over every non-empty set of armed mailboxes under several priority patterns that produce ties. Each set is drained one grant at a time against a minimum computed in the bench.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;

    localparam int PRIO_W  = 4;
    localparam int ID_W    = 29;
    localparam int DLC_W   = 4;
    localparam int MODE_W  = 3;

    // host word selects
    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_ID   = 3'd1;
    localparam logic [2:0] SEL_DLO  = 3'd2;
    localparam logic [2:0] SEL_DHI  = 3'd3;
    localparam logic [2:0] SEL_CTRL = 3'd4;

    // mode values
    localparam logic [MODE_W-1:0] MODE_OFF = 3'd0;
    localparam logic [MODE_W-1:0] MODE_TX  = 3'd3;

    // field positions
    localparam int MODE_LSB = 24;
    localparam int PRIO_LSB = 16;
    localparam int ID_EXT   = 29;
    localparam int CTRL_GO  = 23;
    localparam int CTRL_RTR = 20;
    localparam int DLC_LSB  = 16;

    typedef struct packed {
        logic [ID_W-1:0]  ident;
        logic             ext;
        logic             rtr;
        logic [DLC_W-1:0] dlc;
        logic [63:0]      data;
    } txmb_frame_t;

endpackage

// File: rtl/can_txmb_slot.sv
module can_txmb_slot
    import can_txmb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              lock,
    input  logic              fin_done,
    input  logic              fin_abort,
    output logic              pending,
    output logic [PRIO_W-1:0] prio,
    output txmb_frame_t       frame,
    output logic              rdy,
    output logic              abt,
    output logic              irq
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [PRIO_W-1:0] prio;
        txmb_frame_t       frm;
        logic              req;
        logic              abt;
        logic              irq;
    } slot_t;

    slot_t slot_q, slot_d;

    always_comb begin
        slot_d = slot_q;
        if (wr_en && !lock) begin
            case (wr_sel)
                SEL_MODE: begin
                    slot_d.mode = wr_data[MODE_LSB +: MODE_W];
                    slot_d.prio = wr_data[PRIO_LSB +: PRIO_W];
                end
                SEL_ID: begin
                    if (slot_q.mode == MODE_OFF) begin
                        slot_d.frm.ident = wr_data[ID_W-1:0];
                        slot_d.frm.ext   = wr_data[ID_EXT];
                    end
                end
                SEL_DLO: slot_d.frm.data[31:0]  = wr_data;
                SEL_DHI: slot_d.frm.data[63:32] = wr_data;
                SEL_CTRL: begin
                    slot_d.irq = 1'b0;
                    if (wr_data[CTRL_GO]) begin
                        slot_d.req     = 1'b1;
                        slot_d.abt     = 1'b0;
                        slot_d.frm.dlc = wr_data[DLC_LSB +: DLC_W];
                        slot_d.frm.rtr = wr_data[CTRL_RTR];
                    end
                end
                default: ;
            endcase
        end
        if (fin_done || fin_abort) begin
            slot_d.req = 1'b0;
            slot_d.abt = fin_abort;
            slot_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign pending = slot_q.req && (slot_q.mode == MODE_TX);
    assign prio    = slot_q.prio;
    assign frame   = slot_q.frm;
    assign rdy     = ~slot_q.req;
    assign abt     = slot_q.abt;
    assign irq     = slot_q.irq;

    AST_ID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ID && slot_q.mode != MODE_OFF) |=> $stable(frame.ident)); // R7
    AST_FIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_done || fin_abort) |=> (irq && rdy)); // R9
    AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fin_abort |=> abt); // R10
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> $stable(frame)); // R8

endmodule

// File: rtl/can_txmb_pick.sv
module can_txmb_pick
    import can_txmb_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_MB-1:0]             pend,
    input  logic [NUM_MB-1:0][PRIO_W-1:0] prio,
    output logic                          any,
    output logic [IDX_W-1:0]              best
);

    logic [PRIO_W-1:0] best_p;

    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        any    = 1'b0;
        best   = '0;
        best_p = '1;
        for (int i = 0; i < NUM_MB; i++) begin
            if (pend[i] && (!any || prio[i] < best_p)) begin
                any    = 1'b1;
                best   = IDX_W'(i);
                best_p = prio[i];
            end
        end
    end

endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
    import can_txmb_pkg::*;
#(
    parameter  int NUM_MB = 4,
    localparam int IDX_W  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [IDX_W-1:0]  host_mb,
    input  logic [2:0]        host_sel,
    input  logic [31:0]       host_wdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [IDX_W-1:0]  tx_mb,
    output logic [ID_W-1:0]   tx_id,
    output logic              tx_ext,
    output logic              tx_rtr,
    output logic [DLC_W-1:0]  tx_dlc,
    output logic [63:0]       tx_data,
    input  logic              res_done,
    input  logic              res_abort,
    output logic [NUM_MB-1:0] mb_ready,
    output logic [NUM_MB-1:0] mb_abort,
    output logic [NUM_MB-1:0] mb_irq
);

    typedef struct packed {
        logic             valid;
        logic             busy;
        logic [IDX_W-1:0] sel;
    } arb_t;

    arb_t arb_q, arb_d;

    logic [NUM_MB-1:0]             pend_w;
    logic [NUM_MB-1:0][PRIO_W-1:0] prio_w;
    logic [NUM_MB-1:0]             hit_w;
    logic [NUM_MB-1:0]             lock_w;
    logic [NUM_MB-1:0]             fin_d_w;
    logic [NUM_MB-1:0]             fin_a_w;
    txmb_frame_t                   frame_w [NUM_MB];
    logic                          any_w;
    logic [IDX_W-1:0]              best_w;
    logic                          accept_w;
    logic                          result_w;
    txmb_frame_t                   cur_w;

    assign accept_w = arb_q.valid && tx_ready;
    assign result_w = res_done || res_abort;

    for (genvar g = 0; g < NUM_MB; g++) begin : g_slot
        logic is_sel;
        assign is_sel     = (arb_q.sel == IDX_W'(g));
        assign hit_w[g]   = host_wr && (host_mb == IDX_W'(g));
        assign lock_w[g]  = is_sel && (arb_q.busy || accept_w);
        assign fin_d_w[g] = is_sel && arb_q.busy && res_done && !res_abort;
        assign fin_a_w[g] = is_sel && arb_q.busy && res_abort;

        can_txmb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (hit_w[g]),
            .wr_sel    (host_sel),
            .wr_data   (host_wdata),
            .lock      (lock_w[g]),
            .fin_done  (fin_d_w[g]),
            .fin_abort (fin_a_w[g]),
            .pending   (pend_w[g]),
            .prio      (prio_w[g]),
            .frame     (frame_w[g]),
            .rdy       (mb_ready[g]),
            .abt       (mb_abort[g]),
            .irq       (mb_irq[g])
        );
    end

    can_txmb_pick #(
        .NUM_MB (NUM_MB),
        .IDX_W  (IDX_W)
    ) u_pick (
        .pend (pend_w),
        .prio (prio_w),
        .any  (any_w),
        .best (best_w)
    );

    always_comb begin
        arb_d = arb_q;
        if (arb_q.busy) begin
            if (result_w) begin
                arb_d.busy  = 1'b0;
                arb_d.valid = 1'b0;
            end
        end else if (accept_w) begin
            arb_d.busy  = 1'b1;
            arb_d.valid = 1'b0;
        end else begin
            arb_d.valid = any_w;
            if (any_w) arb_d.sel = best_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign cur_w    = frame_w[arb_q.sel];
    assign tx_valid = arb_q.valid;
    assign tx_mb    = arb_q.sel;
    assign tx_id    = cur_w.ident;
    assign tx_ext   = cur_w.ext;
    assign tx_rtr   = cur_w.rtr;
    assign tx_dlc   = cur_w.dlc;
    assign tx_data  = cur_w.data;

    AST_BUSY_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        arb_q.busy |-> !tx_valid); // R8
    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_q.busy && !result_w) |=> (arb_q.busy && $stable(tx_mb))); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_q.busy && !accept_w && !any_w) |=> (!tx_valid && $stable(tx_mb))); // R12
    AST_RES_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!arb_q.busy && result_w && !host_wr) |=>
            ($stable(mb_irq) && $stable(mb_ready) && $stable(mb_abort))); // R13

endmodule

// File: tb/can_txmb_arbiter_tb.sv
`timescale 1ns/1ps
module can_txmb_arbiter_tb_top;

    localparam int NMB = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr;
    logic [1:0]  host_mb;
    logic [2:0]  host_sel;
    logic [31:0] host_wdata;
    logic        tx_valid;
    logic        tx_ready;
    logic [1:0]  tx_mb;
    logic [28:0] tx_id;
    logic        tx_ext;
    logic        tx_rtr;
    logic [3:0]  tx_dlc;
    logic [63:0] tx_data;
    logic        res_done;
    logic        res_abort;
    logic [3:0]  mb_ready;
    logic [3:0]  mb_abort;
    logic [3:0]  mb_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    can_txmb_arbiter #(.NUM_MB(NMB)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_mb(host_mb), .host_sel(host_sel), .host_wdata(host_wdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_mb(tx_mb),
        .tx_id(tx_id), .tx_ext(tx_ext), .tx_rtr(tx_rtr), .tx_dlc(tx_dlc), .tx_data(tx_data),
        .res_done(res_done), .res_abort(res_abort),
        .mb_ready(mb_ready), .mb_abort(mb_abort), .mb_irq(mb_irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int mb, input logic [2:0] sel, input logic [31:0] d);
        host_wr    = 1'b1;
        host_mb    = 2'(mb);
        host_sel   = sel;
        host_wdata = d;
        tick();
        host_wr    = 1'b0;
    endtask

    function automatic logic [31:0] mode_w(input int mode, input int pr);
        return (32'(mode & 7) << 24) | (32'(pr & 15) << 16);
    endfunction

    function automatic logic [31:0] ctrl_w(input bit go, input bit rtr, input int dlc);
        return (32'(go) << 23) | (32'(rtr) << 20) | (32'(dlc & 15) << 16);
    endfunction

    task automatic accept_finish(input bit abort);
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
        if (abort) res_abort = 1'b1;
        else       res_done  = 1'b1;
        tick();
        res_done  = 1'b0;
        res_abort = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [3:0] irq_snap;
        rst_n = 1'b0; host_wr = 1'b0; host_mb = '0; host_sel = '0; host_wdata = '0;
        tx_ready = 1'b0; res_done = 1'b0; res_abort = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1 tx_valid", 64'(tx_valid), 0);
        chk("R1 tx_mb", 64'(tx_mb), 0);
        chk("R1 mb_ready", 64'(mb_ready), 64'hf);
        chk("R1 mb_abort", 64'(mb_abort), 0);
        chk("R1 mb_irq", 64'(mb_irq), 0);

        // load mailbox 2 while disabled
        wr(2, 3'd1, 32'h2000_0000 | 32'h1abc_def1);
        wr(2, 3'd2, 32'h4433_2211);
        wr(2, 3'd3, 32'h8877_6655);
        wr(2, 3'd0, mode_w(1, 0));
        wr(2, 3'd4, ctrl_w(1, 1, 8));
        tick();
        chk("R2 non-tx mode not offered", 64'(tx_valid), 0);
        chk("R5 ready low when armed", 64'(mb_ready[2]), 0);
        wr(2, 3'd0, mode_w(3, 7));
        tick();
        chk("R2 tx mode offered", 64'(tx_valid), 1);
        chk("R2 index", 64'(tx_mb), 2);
        chk("R6 id", 64'(tx_id), 64'h1abc_def1);
        chk("R6 ext", 64'(tx_ext), 1);
        chk("R6 data", tx_data, 64'h8877_6655_4433_2211);
        chk("R5 dlc", 64'(tx_dlc), 8);
        chk("R5 rtr", 64'(tx_rtr), 1);

        // R7 id write ignored outside disabled mode
        wr(2, 3'd1, 32'h0000_0123);
        tick();
        chk("R7 id unchanged", 64'(tx_id), 64'h1abc_def1);
        chk("R7 ext unchanged", 64'(tx_ext), 1);

        // R8 re-evaluation before acceptance
        wr(1, 3'd0, mode_w(3, 2));
        wr(1, 3'd4, ctrl_w(1, 0, 3));
        tick();
        chk("R8 re-evaluated to mb1", 64'(tx_mb), 1);
        chk("R8 valid", 64'(tx_valid), 1);
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
        wr(0, 3'd0, mode_w(3, 0));
        wr(0, 3'd4, ctrl_w(1, 0, 1));
        tick();
        chk("R8 no offer in flight", 64'(tx_valid), 0);
        chk("R8 index frozen", 64'(tx_mb), 1);
        wr(1, 3'd2, 32'h0000_dead);
        wr(1, 3'd4, ctrl_w(1, 1, 15));
        wr(1, 3'd0, mode_w(0, 9));
        tick();
        chk("R8 dlc frozen", 64'(tx_dlc), 3);
        chk("R8 rtr frozen", 64'(tx_rtr), 0);
        chk("R8 data frozen", tx_data, 0);
        chk("R8 ready still low", 64'(mb_ready[1]), 0);
        res_done = 1'b1;
        tick();
        res_done = 1'b0;
        chk("R9 ready", 64'(mb_ready[1]), 1);
        chk("R9 abort", 64'(mb_abort[1]), 0);
        chk("R9 irq", 64'(mb_irq[1]), 1);
        tick();
        chk("R3 prio0 wins", 64'(tx_mb), 0);
        chk("R3 valid", 64'(tx_valid), 1);

        // R10 abort
        accept_finish(1'b1);
        chk("R10 ready", 64'(mb_ready[0]), 1);
        chk("R10 abort", 64'(mb_abort[0]), 1);
        chk("R10 irq", 64'(mb_irq[0]), 1);
        tick();
        chk("R3 next mb2", 64'(tx_mb), 2);

        // R11 irq clear by control write without go
        wr(0, 3'd4, 32'h0);
        chk("R11 irq0 cleared", 64'(mb_irq[0]), 0);
        chk("R11 irq1 kept", 64'(mb_irq[1]), 1);
        chk("R11 abort kept", 64'(mb_abort[0]), 1);
        wr(0, 3'd4, ctrl_w(1, 0, 2));
        chk("R5 abort cleared on arm", 64'(mb_abort[0]), 0);
        tick();
        chk("R3 rearmed mb0", 64'(tx_mb), 0);
        accept_finish(1'b0);
        tick();
        chk("R3 mb2 last", 64'(tx_mb), 2);
        accept_finish(1'b0);

        // R12 idle hold
        tick();
        chk("R12 valid low", 64'(tx_valid), 0);
        chk("R12 index held", 64'(tx_mb), 2);
        repeat (3) tick();
        chk("R12 index still held", 64'(tx_mb), 2);

        // R13 results ignored when idle
        irq_snap = mb_irq;
        res_done = 1'b1;
        tick();
        res_done = 1'b0;
        res_abort = 1'b1;
        tick();
        res_abort = 1'b0;
        chk("R13 irq unchanged", 64'(mb_irq), 64'(irq_snap));
        chk("R13 ready unchanged", 64'(mb_ready), 64'hf);
        chk("R13 abort unchanged", 64'(mb_abort), 0);

        for (int i = 0; i < NMB; i++) wr(i, 3'd4, 32'h0);
        chk("R11 all irq cleared", 64'(mb_irq), 0);

        // R3 R4 sweep over armed sets and priority patterns
        for (int seed = 0; seed < 4; seed++) begin
            for (int mask = 1; mask < 16; mask++) begin
                int pr [NMB];
                int rem;
                for (int i = 0; i < NMB; i++) begin
                    pr[i] = ((seed + 1) * (i + 1) * 5 + seed) % 3 + seed * 4;
                    wr(i, 3'd0, mode_w(3, pr[i]));
                end
                for (int i = 0; i < NMB; i++)
                    if (mask[i]) wr(i, 3'd4, ctrl_w(1, 0, i));
                rem = mask;
                while (rem != 0) begin
                    int exp_i;
                    exp_i = -1;
                    for (int i = 0; i < NMB; i++)
                        if (rem[i] && (exp_i < 0 || pr[i] < pr[exp_i])) exp_i = i;
                    tick();
                    chk("R3 R4 sweep valid", 64'(tx_valid), 1);
                    chk("R3 R4 sweep index", 64'(tx_mb), 64'(exp_i));
                    chk("R5 sweep dlc", 64'(tx_dlc), 64'(exp_i));
                    accept_finish(1'b0);
                    chk("R9 sweep irq", 64'(mb_irq[exp_i]), 1);
                    chk("R9 sweep ready", 64'(mb_ready[exp_i]), 1);
                    wr(exp_i, 3'd4, 32'h0);
                    chk("R11 sweep irq clear", 64'(mb_irq[exp_i]), 0);
                    rem = rem & ~(1 << exp_i);
                end
                tick();
                chk("R12 sweep drained", 64'(tx_valid), 0);
            end
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule